// File: doc/BRIEF.md
# MD5 compression engine

This block runs the MD5 compression function over a message that has already been padded into 512-bit blocks. It holds the four 32-bit chaining words. It takes each block as sixteen 32-bit words through a request/accept handshake. It runs the 64 MD5 steps, and then adds the working words back into the chaining words modulo 2^32. The chaining words are always visible on the four digest outputs. A ready flag marks them as the final digest once the block that was flagged as final has been folded in.

The round-1 steps run in the same cycle as their word is accepted, so sixteen steps are complete when intake ends. The remaining 48 steps take one cycle each, and one more cycle performs the chaining addition. The request line is therefore low for exactly 49 cycles after the sixteenth word. A start pulse begins a new message: it reloads the standard initial chaining values, clears ready and discards any block in progress. Padding and the scheduling of several messages belong to the surrounding logic.

Top module: `md5_engine`

## Requirements
- R1: After reset, req is 1, ready is 0, and the digest outputs hold 0x67452301, 0xEFCDAB89, 0x98BADCFE and 0x10325476 on dig_a, dig_b, dig_c and dig_d.
- R2: A start pulse reloads those four initial values and clears ready, both visible one cycle later, and raises req. A block that is partly loaded or still being computed is discarded, and a word offered in the start cycle is not taken.
- R3: req falls in the cycle after the 16th word of a block is accepted. It stays low for exactly 49 cycles, and it is high again from the 50th cycle on.
- R4: For one block loaded after start, the digest equals the MD5 compression of the initial values with that block. Word k of the block is the k-th accepted word, and each word is taken as a little-endian 32-bit value.
- R5: For several blocks in one message, each block's final working words are added modulo 2^32 to the chaining words held before that block. The sum becomes the new digest. Between those additions and start pulses, the digest outputs do not change.
- R6: blk_last is sampled with the 16th word of a block. ready rises in the same cycle that req returns after a block sampled with blk_last=1. ready does not rise after a block sampled with blk_last=0, and it stays high until the next start.
- R7: A word is accepted only on a clock edge where req and ack are both 1. Words and blk_last values offered with ack=1 while req is low have no effect on the digest.
- R8: Idle cycles with ack=0 between the words of a block do not change the digest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new message: reload initial chaining values |
| ack | input | 1 | The word on din is valid; it is taken when req is high |
| din | input | 32 | Message word |
| blk_last | input | 1 | With the 16th word: this block ends the message |
| req | output | 1 | The engine can take words |
| ready | output | 1 | The digest outputs hold a finished message digest |
| dig_a | output | 32 | Chaining word A |
| dig_b | output | 32 | Chaining word B |
| dig_c | output | 32 | Chaining word C |
| dig_d | output | 32 | Chaining word D |

## Verification
The effects of start and reset appear one cycle after the edge that samples them. req falls one cycle after the 16th accepted word. The updated digest and ready appear on the same edge where req returns, which is 49 cycles after that word. The bench drives and samples only on falling clock edges. After the 16th word it counts the falling edges at which req is low, and it expects 49. At the first falling edge with req high, it compares the digest and ready against a software model of the compression. That model builds its step constants from the sine function.

// File: rtl/md5_pkg.sv
package md5_pkg;

    localparam int WORD_W      = 32;
    localparam int BLOCK_WORDS = 16;
    localparam int STEPS       = 64;
    localparam int STEP_W      = $clog2(STEPS);
    localparam int IDX_W       = $clog2(BLOCK_WORDS);
    localparam int TAIL_CYCLES = STEPS - BLOCK_WORDS + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } state_t;

    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_CALC = 2'd1,
        PH_ADD  = 2'd2
    } phase_t;

    localparam state_t INIT_STATE = '{
        a: 32'h67452301,
        b: 32'hEFCDAB89,
        c: 32'h98BADCFE,
        d: 32'h10325476
    };

    // additive constant of each step
    function automatic word_t step_const(input step_t s);
        case (s)
            6'd0:  return 32'hd76aa478; 6'd1:  return 32'he8c7b756;
            6'd2:  return 32'h242070db; 6'd3:  return 32'hc1bdceee;
            6'd4:  return 32'hf57c0faf; 6'd5:  return 32'h4787c62a;
            6'd6:  return 32'ha8304613; 6'd7:  return 32'hfd469501;
            6'd8:  return 32'h698098d8; 6'd9:  return 32'h8b44f7af;
            6'd10: return 32'hffff5bb1; 6'd11: return 32'h895cd7be;
            6'd12: return 32'h6b901122; 6'd13: return 32'hfd987193;
            6'd14: return 32'ha679438e; 6'd15: return 32'h49b40821;
            6'd16: return 32'hf61e2562; 6'd17: return 32'hc040b340;
            6'd18: return 32'h265e5a51; 6'd19: return 32'he9b6c7aa;
            6'd20: return 32'hd62f105d; 6'd21: return 32'h02441453;
            6'd22: return 32'hd8a1e681; 6'd23: return 32'he7d3fbc8;
            6'd24: return 32'h21e1cde6; 6'd25: return 32'hc33707d6;
            6'd26: return 32'hf4d50d87; 6'd27: return 32'h455a14ed;
            6'd28: return 32'ha9e3e905; 6'd29: return 32'hfcefa3f8;
            6'd30: return 32'h676f02d9; 6'd31: return 32'h8d2a4c8a;
            6'd32: return 32'hfffa3942; 6'd33: return 32'h8771f681;
            6'd34: return 32'h6d9d6122; 6'd35: return 32'hfde5380c;
            6'd36: return 32'ha4beea44; 6'd37: return 32'h4bdecfa9;
            6'd38: return 32'hf6bb4b60; 6'd39: return 32'hbebfbc70;
            6'd40: return 32'h289b7ec6; 6'd41: return 32'heaa127fa;
            6'd42: return 32'hd4ef3085; 6'd43: return 32'h04881d05;
            6'd44: return 32'hd9d4d039; 6'd45: return 32'he6db99e5;
            6'd46: return 32'h1fa27cf8; 6'd47: return 32'hc4ac5665;
            6'd48: return 32'hf4292244; 6'd49: return 32'h432aff97;
            6'd50: return 32'hab9423a7; 6'd51: return 32'hfc93a039;
            6'd52: return 32'h655b59c3; 6'd53: return 32'h8f0ccc92;
            6'd54: return 32'hffeff47d; 6'd55: return 32'h85845dd1;
            6'd56: return 32'h6fa87e4f; 6'd57: return 32'hfe2ce6e0;
            6'd58: return 32'ha3014314; 6'd59: return 32'h4e0811a1;
            6'd60: return 32'hf7537e82; 6'd61: return 32'hbd3af235;
            6'd62: return 32'h2ad7d2bb; default: return 32'heb86d391;
        endcase
    endfunction

    // left-rotate distance: round in s[5:4], position in round modulo 4
    function automatic logic [4:0] rot_amt(input step_t s);
        case ({s[5:4], s[1:0]})
            4'h0: return 5'd7;  4'h1: return 5'd12; 4'h2: return 5'd17; 4'h3: return 5'd22;
            4'h4: return 5'd5;  4'h5: return 5'd9;  4'h6: return 5'd14; 4'h7: return 5'd20;
            4'h8: return 5'd4;  4'h9: return 5'd11; 4'hA: return 5'd16; 4'hB: return 5'd23;
            4'hC: return 5'd6;  4'hD: return 5'd10; 4'hE: return 5'd15; default: return 5'd21;
        endcase
    endfunction

    // which buffered word a step consumes
    function automatic idx_t msg_index(input step_t s);
        idx_t i;
        i = s[IDX_W-1:0];
        case (s[5:4])
            2'd0:    return i;
            2'd1:    return idx_t'(i * 4'd5 + 4'd1);
            2'd2:    return idx_t'(i * 4'd3 + 4'd5);
            default: return idx_t'(i * 4'd7);
        endcase
    endfunction

    function automatic word_t rotl(input word_t x, input logic [4:0] n);
        logic [2*WORD_W-1:0] t;
        t = {x, x} << n;
        return t[2*WORD_W-1:WORD_W];
    endfunction

    function automatic word_t mix(input logic [1:0] rnd, input word_t b,
                                  input word_t c, input word_t d);
        case (rnd)
            2'd0:    return (b & c) | (~b & d);
            2'd1:    return (b & d) | (c & ~d);
            2'd2:    return b ^ c ^ d;
            default: return c ^ (b | ~d);
        endcase
    endfunction

    function automatic state_t step_apply(input state_t s, input step_t k, input word_t m);
        word_t  sum;
        state_t o;
        sum = s.a + mix(k[5:4], s.b, s.c, s.d) + step_const(k) + m;
        o.a = s.d;
        o.b = s.b + rotl(sum, rot_amt(k));
        o.c = s.b;
        o.d = s.c;
        return o;
    endfunction

    function automatic state_t state_add(input state_t x, input state_t y);
        state_t o;
        o.a = x.a + y.a;
        o.b = x.b + y.b;
        o.c = x.c + y.c;
        o.d = x.d + y.d;
        return o;
    endfunction

endpackage

// File: rtl/md5_sequencer.sv
module md5_sequencer
    import md5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  ack,
    input  logic  last_in,
    output logic  req,
    output logic  fire,
    output logic  do_add,
    output logic  blk_final,
    output step_t step
);

    phase_t phase;
    logic   fin_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            phase <= PH_LOAD;
            step  <= '0;
            fin_q <= 1'b0;
        end else begin
            case (phase)
                PH_LOAD: begin
                    if (ack) begin
                        step <= step + 1'b1;
                        if (step == step_t'(BLOCK_WORDS - 1)) begin
                            phase <= PH_CALC;
                            fin_q <= last_in;
                        end
                    end
                end
                PH_CALC: begin
                    step <= step + 1'b1;
                    if (step == step_t'(STEPS - 1)) phase <= PH_ADD;
                end
                PH_ADD:  phase <= PH_LOAD;
                default: phase <= PH_LOAD;
            endcase
        end
    end

    assign req       = (phase == PH_LOAD);
    assign fire      = (req && ack) || (phase == PH_CALC);
    assign do_add    = (phase == PH_ADD);
    assign blk_final = fin_q;

endmodule

// File: rtl/md5_msgbuf.sv
module md5_msgbuf
    import md5_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  word_t wr_data,
    input  idx_t  rd_idx,
    output word_t rd_data
);

    word_t mem [BLOCK_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/md5_round.sv
module md5_round
    import md5_pkg::*;
(
    input  state_t cur,
    input  step_t  step,
    input  word_t  msg,
    output state_t nxt
);

    always_comb begin
        nxt = step_apply(cur, step, msg);
    end

endmodule

// File: rtl/md5_state.sv
module md5_state
    import md5_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   fire,
    input  logic   do_add,
    input  logic   blk_final,
    input  state_t step_out,
    output state_t work,
    output state_t chain,
    output logic   ready
);

    state_t folded;

    assign folded = state_add(chain, work);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            work  <= INIT_STATE;
            chain <= INIT_STATE;
            ready <= 1'b0;
        end else if (do_add) begin
            work  <= folded;
            chain <= folded;
            ready <= ready | blk_final;
        end else if (fire) begin
            work  <= step_out;
        end
    end

endmodule

// File: rtl/md5_engine.sv
module md5_engine
    import md5_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        ack,
    input  logic [31:0] din,
    input  logic        blk_last,
    output logic        req,
    output logic        ready,
    output logic [31:0] dig_a,
    output logic [31:0] dig_b,
    output logic [31:0] dig_c,
    output logic [31:0] dig_d
);

    logic   fire;
    logic   do_add;
    logic   blk_final;
    step_t  step;
    word_t  buf_word;
    word_t  msg;
    state_t work;
    state_t chain;
    state_t step_out;

    md5_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ack       (ack),
        .last_in   (blk_last),
        .req       (req),
        .fire      (fire),
        .do_add    (do_add),
        .blk_final (blk_final),
        .step      (step)
    );

    md5_msgbuf u_buf (
        .clk     (clk),
        .wr_en   (req && ack),
        .wr_idx  (step[IDX_W-1:0]),
        .wr_data (din),
        .rd_idx  (msg_index(step)),
        .rd_data (buf_word)
    );

    // round-1 steps consume the word being accepted
    assign msg = req ? din : buf_word;

    md5_round u_round (
        .cur  (work),
        .step (step),
        .msg  (msg),
        .nxt  (step_out)
    );

    md5_state u_state (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .fire      (fire),
        .do_add    (do_add),
        .blk_final (blk_final),
        .step_out  (step_out),
        .work      (work),
        .chain     (chain),
        .ready     (ready)
    );

    assign dig_a = chain.a;
    assign dig_b = chain.b;
    assign dig_c = chain.c;
    assign dig_d = chain.d;

endmodule

// File: rtl/md5_engine_chk.sv
module md5_engine_chk
    import md5_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        ack,
    input logic        req,
    input logic        ready,
    input logic [31:0] dig_a,
    input logic [31:0] dig_b,
    input logic [31:0] dig_c,
    input logic [31:0] dig_d
);

    localparam int WAIT_W = $clog2(TAIL_CYCLES + 2);

    logic [IDX_W-1:0]  acc_cnt;
    logic [WAIT_W-1:0] wait_cnt;
    logic              drop_evt;

    assign drop_evt = req && ack && (acc_cnt == IDX_W'(BLOCK_WORDS - 1)) && !start;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            acc_cnt  <= '0;
            wait_cnt <= '0;
        end else begin
            if (req && ack) acc_cnt <= acc_cnt + 1'b1;
            if (drop_evt)
                wait_cnt <= WAIT_W'(1);
            else if (wait_cnt != '0 && wait_cnt != WAIT_W'(TAIL_CYCLES + 1))
                wait_cnt <= wait_cnt + 1'b1;
            else
                wait_cnt <= '0;
        end
    end

    // R3: request falls after the sixteenth word
    a_r3_req_drops: assert property (@(posedge clk) disable iff (rst)
        drop_evt |=> !req);

    // R3: request stays low through the tail
    a_r3_busy_window: assert property (@(posedge clk) disable iff (rst)
        (wait_cnt >= WAIT_W'(1) && wait_cnt <= WAIT_W'(TAIL_CYCLES)) |-> !req);

    // R3: request returns after the tail
    a_r3_req_returns: assert property (@(posedge clk) disable iff (rst)
        (wait_cnt == WAIT_W'(TAIL_CYCLES + 1)) |-> req);

    // R2: start reloads the initial chaining words
    a_r2_start_reload: assert property (@(posedge clk) disable iff (rst)
        start |=> (!ready && req && dig_a == INIT_STATE.a && dig_b == INIT_STATE.b
                   && dig_c == INIT_STATE.c && dig_d == INIT_STATE.d));

    // R6: ready holds until start
    a_r6_ready_hold: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready);

    // R6: ready rises only at the end of a block
    a_r6_ready_at_end: assert property (@(posedge clk) disable iff (rst)
        (!ready && !start && wait_cnt != WAIT_W'(TAIL_CYCLES)) |=> !ready);

    // R5: digest changes only at a chaining addition or start
    a_r5_digest_stable: assert property (@(posedge clk) disable iff (rst)
        (!start && wait_cnt != WAIT_W'(TAIL_CYCLES)) |=>
            ($stable(dig_a) && $stable(dig_b) && $stable(dig_c) && $stable(dig_d)));

endmodule

bind md5_engine md5_engine_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ack   (ack),
    .req   (req),
    .ready (ready),
    .dig_a (dig_a),
    .dig_b (dig_b),
    .dig_c (dig_c),
    .dig_d (dig_d)
);

// File: tb/test_md5_engine.sv
`timescale 1ns/1ps
module test_md5_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ack = 1'b0;
    logic [31:0] din = '0;
    logic        blk_last = 1'b0;
    logic        req, ready;
    logic [31:0] dig_a, dig_b, dig_c, dig_d;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [127:0] IV128 = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476};

    always #10 clk = ~clk;

    md5_engine i_md5_engine (
        .clk(clk), .rst(rst), .start(start), .ack(ack), .din(din),
        .blk_last(blk_last), .req(req), .ready(ready),
        .dig_a(dig_a), .dig_b(dig_b), .dig_c(dig_c), .dig_d(dig_d)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] kval(input int i);
        real x;
        x = $sin(real'(i + 1));
        if (x < 0.0) x = -x;
        return 32'(longint'($floor(x * 4294967296.0)));
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [127:0] ref_block(input logic [127:0] st, input logic [511:0] blk);
        int sh [4][4];
        logic [31:0] a, b, c, d, f, t;
        int g;
        sh = '{'{7, 12, 17, 22}, '{5, 9, 14, 20}, '{4, 11, 16, 23}, '{6, 10, 15, 21}};
        {a, b, c, d} = st;
        for (int i = 0; i < 64; i++) begin
            if (i < 16) begin f = (b & c) | (~b & d); g = i; end
            else if (i < 32) begin f = (d & b) | (~d & c); g = (5 * i + 1) % 16; end
            else if (i < 48) begin f = b ^ c ^ d; g = (3 * i + 5) % 16; end
            else begin f = c ^ (b | ~d); g = (7 * i) % 16; end
            t = a + f + kval(i) + blk[32*g +: 32];
            a = d; d = c; c = b;
            b = b + rl(t, sh[i/16][i%4]);
        end
        return {st[127:96] + a, st[95:64] + b, st[63:32] + c, st[31:0] + d};
    endfunction

    function automatic logic [511:0] rand_block();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        ack = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // feeds one block; returns the number of falling edges with req low afterwards
    task automatic send_block(input logic [511:0] blk, input bit lst, input int gapmax,
                              input bit junk, output int lowcnt);
        for (int i = 0; i < 16; i++) begin
            int g;
            g = (gapmax > 0) ? int'($urandom_range(gapmax, 0)) : 0;
            repeat (g) begin @(negedge clk); ack = 1'b0; end
            @(negedge clk);
            while (!req) @(negedge clk);
            ack = 1'b1;
            din = blk[32*i +: 32];
            blk_last = lst;
        end
        @(posedge clk);
        lowcnt = 0;
        @(negedge clk);
        while (!req) begin
            lowcnt++;
            ack = junk;
            din = $urandom;
            blk_last = 1'($urandom);
            @(negedge clk);
        end
        ack = 1'b0;
    endtask

    function automatic logic [127:0] dig();
        return {dig_a, dig_b, dig_c, dig_d};
    endfunction

    task automatic run_message(input int nb, input int gapmax, input string tag);
        logic [127:0] exp;
        logic [511:0] blk;
        int low;
        exp = IV128;
        pulse_start();
        for (int k = 0; k < nb; k++) begin
            blk = rand_block();
            exp = ref_block(exp, blk);
            send_block(blk, k == nb - 1, gapmax, 1'($urandom), low);
            check(low == 49, {tag, " R3 tail length"}, 128'(low), 128'd49);
            check(dig() == exp, {tag, " R5 chained digest"}, dig(), exp);
            check(ready == (k == nb - 1), {tag, " R6 ready after block"},
                  128'(ready), 128'(k == nb - 1));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [511:0] blk;
        logic [127:0] exp;
        int low;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req == 1'b1, "R1 req after reset", 128'(req), 128'd1);
        check(ready == 1'b0, "R1 ready after reset", 128'(ready), 128'd0);
        check(dig() == IV128, "R1 digest after reset", dig(), IV128);

        // empty message: single padded block
        pulse_start();
        blk = '0;
        blk[31:0] = 32'h00000080;
        send_block(blk, 1'b1, 0, 1'b0, low);
        check(low == 49, "R3 tail length empty", 128'(low), 128'd49);
        exp = {32'hd98c1dd4, 32'h04b2008f, 32'h980980e9, 32'h7e42f8ec};
        check(dig() == exp, "R4 empty-message digest", dig(), exp);
        check(ready == 1'b1, "R6 ready after final block", 128'(ready), 128'd1);
        repeat (5) @(negedge clk);
        check(ready == 1'b1, "R6 ready holds", 128'(ready), 128'd1);
        check(dig() == exp, "R5 digest holds while idle", dig(), exp);

        pulse_start();
        check(ready == 1'b0, "R2 start clears ready", 128'(ready), 128'd0);
        check(dig() == IV128, "R2 start reloads digest", dig(), IV128);

        // "abc" with idle gaps between words and junk during the tail
        blk = '0;
        blk[31:0] = 32'h80636261;
        blk[14*32 +: 32] = 32'h00000018;
        send_block(blk, 1'b1, 3, 1'b1, low);
        exp = {32'h98500190, 32'hb04fd23c, 32'h7d3f96d6, 32'h727fe128};
        check(dig() == exp, "R8 R7 abc digest with gaps and junk", dig(), exp);
        check(low == 49, "R3 tail length abc", 128'(low), 128'd49);

        // start during computation discards the block
        pulse_start();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ack = 1'b1;
            din = $urandom;
            blk_last = 1'b1;
        end
        @(negedge clk);
        ack = 1'b0;
        repeat (10) @(negedge clk);
        check(req == 1'b0, "R3 busy during tail", 128'(req), 128'd0);
        start = 1'b1;
        ack = 1'b1;
        din = 32'hdeadbeef;
        @(negedge clk);
        start = 1'b0;
        ack = 1'b0;
        check(req == 1'b1, "R2 req after abort", 128'(req), 128'd1);
        check(dig() == IV128, "R2 digest after abort", dig(), IV128);
        check(ready == 1'b0, "R2 ready after abort", 128'(ready), 128'd0);
        blk = rand_block();
        send_block(blk, 1'b1, 0, 1'b0, low);
        exp = ref_block(IV128, blk);
        check(dig() == exp, "R2 R4 block after abort", dig(), exp);

        // start while part of a block is loaded
        pulse_start();
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            ack = 1'b1;
            din = $urandom;
        end
        @(negedge clk);
        ack = 1'b0;
        pulse_start();
        blk = rand_block();
        send_block(blk, 1'b1, 1, 1'b1, low);
        exp = ref_block(IV128, blk);
        check(dig() == exp, "R2 partial block discarded", dig(), exp);

        // multi-block and random messages
        run_message(3, 0, "directed3");
        for (int m = 0; m < 6; m++) begin
            run_message(int'($urandom_range(3, 1)), 3, "random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule